// File: doc/BRIEF.md
# Nested Prioritised Interrupt Controller

The controller gathers a parameterised set of level-sensitive peripheral interrupt lines, one non-maskable request and one hard-fault request, and decides which of them the core should service next. Software reaches per-line enable, pending and priority state, plus a relocatable vector-table base, through a small register bus. Set and clear actions go to separate addresses. A 1 in a data bit acts on that line and a 0 leaves it alone.

The block picks the most urgent request that is both pending and enabled. It raises it to the core only when that request strictly outranks the handler now running. It supplies the exception number and the address of the vector-table word to fetch. The core answers with a one-cycle acknowledge when it takes the exception and a one-cycle return pulse when a handler finishes. Inside the block, a stack of active priorities follows nested handlers. The top of that stack is the current execution priority.

Priorities use the internal scale 0 (non-maskable), 1 (hard fault), 2+L for a programmable level L (0 to 3 by default), and 6 for thread level. A lower value is more urgent. The exception number is 2 for the non-maskable request, 3 for hard fault and 16+i for peripheral line i.

Top module: `pic_nest_ctrl`

## Requirements
- R1: After reset, all enables, pending bits and priorities are zero, the table base is zero, no request is raised, and the current priority reads thread level (6).
- R2: Writing to 0x00 sets each enable bit whose data bit is 1, and writing to 0x04 clears it. Zero data bits change nothing. Both addresses read the enable bits in bits [N-1:0].
- R3: Writing to 0x08 sets pending bits and writing to 0x0C clears them, with the same 1-acts rule. Both addresses read the pending bits. A high line that is not active sets its pending bit at the next clock edge.
- R4: The priority byte of line i sits in byte lane i%4 of the word at 0x20+4*(i/4). Only bits [7:6] of each byte are stored. The lower six bits are discarded and read as zero.
- R5: A request is raised only for a line that is both pending and enabled. The smallest priority value wins, and equal values go to the lowest exception number.
- R6: The non-maskable request (value 0) and hard fault (value 1) cannot be disabled. They outrank every programmable level, and the non-maskable request outranks hard fault.
- R7: A pending request whose priority value is equal to or larger than the current priority is not raised.
- R8: A request whose value is strictly below the running handler's priority is raised at once. Taking it nests a new handler and makes its priority current.
- R9: The vector address is the table base plus four times the exception number.
- R10: The table base register at 0x10 keeps bits [31:7], and bits [6:0] read as zero. The initial stack pointer address output equals the base and the reset handler address output equals the base plus 4.
- R11: An acknowledge clears the taken source's pending bit and marks it active. A line still high after its handler returns becomes pending again one cycle later.
- R12: A return pops the newest handler and restores the previous priority. A return with no active handler is ignored. An acknowledge in the same cycle as a return is ignored.
- R13: A software pending-set of a line in the same cycle as its acknowledge leaves that line not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl | input | NUM_IRQ | Peripheral request levels |
| nmi_lvl | input | 1 | Non-maskable request level |
| hardfault_lvl | input | 1 | Hard-fault request level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| exc_req | output | 1 | Exception request to the core |
| exc_num | output | 8 | Exception number of the request |
| exc_vec_addr | output | 32 | Vector word address for the request |
| exc_ack | input | 1 | Core takes the requested exception |
| exc_ret | input | 1 | Core returns from the newest handler |
| cur_prio | output | clog2(2**PRIO_BITS+3) | Current execution priority |
| msp_init_addr | output | 32 | Address of the initial stack pointer word |
| reset_vec_addr | output | 32 | Address of the reset handler word |

## Verification
Two events can land on the same clock edge: the core acknowledging a line, and software writing that line's pending-set bit. The bench drives both in one cycle and then reads the pending register, which must show the bit clear, and the current priority, which must show the taken level. The collision of an acknowledge with a return is handled the same way. The bench drives both together and confirms that the request is still raised, the pending bit is still set and the priority is still thread level.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam logic [7:0] A_ENA_SET  = 8'h00;
  localparam logic [7:0] A_ENA_CLR  = 8'h04;
  localparam logic [7:0] A_PEND_SET = 8'h08;
  localparam logic [7:0] A_PEND_CLR = 8'h0C;
  localparam logic [7:0] A_VT_BASE  = 8'h10;
  localparam int         PRIO_OFF   = 32;

  // Source index 0 = non-maskable, 1 = hard fault, 2+i = peripheral line i
  function automatic logic [7:0] exc_number(input int unsigned src);
    if (src == 0)      return 8'd2;
    else if (src == 1) return 8'd3;
    else               return 8'(src + 14);
  endfunction

  function automatic logic [31:0] vector_addr(input logic [31:0] base,
                                              input logic [7:0]  num);
    return base + {22'd0, num, 2'b00};
  endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 2,
  parameter int VT_LSB    = 7,
  parameter int NSRC      = NUM_IRQ + 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_wr,
  input  logic [7:0]                          bus_addr,
  input  logic [31:0]                         bus_wdata,
  output logic [31:0]                         bus_rdata,
  input  logic [NSRC-1:0]                     hw_level,
  input  logic [NSRC-1:0]                     active,
  input  logic [NSRC-1:0]                     take_oh,
  output logic [NSRC-1:0]                     enable_o,
  output logic [NSRC-1:0]                     pend_o,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]   prio_o,
  output logic [31:0]                         base_o
);

  localparam int NPW = (NUM_IRQ + 3) / 4;

  logic [NUM_IRQ-1:0]                en_q;
  logic [NSRC-1:0]                   pend_q;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;
  logic [31-VT_LSB:0]                base_q;

  logic [NSRC-1:0] sw_set, sw_clr, hw_set, pend_d;

  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    if (bus_wr && bus_addr == A_PEND_SET) sw_set = {bus_wdata[NUM_IRQ-1:0], 2'b00};
    if (bus_wr && bus_addr == A_PEND_CLR) sw_clr = {bus_wdata[NUM_IRQ-1:0], 2'b00};
    hw_set = hw_level & ~active;
    // acknowledge and software clear both override any set
    pend_d = (pend_q | hw_set | sw_set) & ~sw_clr & ~take_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      prio_q <= '0;
      base_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (bus_wr && bus_addr == A_ENA_SET) en_q <= en_q | bus_wdata[NUM_IRQ-1:0];
      if (bus_wr && bus_addr == A_ENA_CLR) en_q <= en_q & ~bus_wdata[NUM_IRQ-1:0];
      if (bus_wr && bus_addr == A_VT_BASE) base_q <= bus_wdata[31:VT_LSB];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (bus_wr && bus_addr == 8'(PRIO_OFF + 4 * (i / 4)))
          prio_q[i] <= bus_wdata[8 * (i % 4) + 7 -: PRIO_BITS];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ENA_SET || bus_addr == A_ENA_CLR)
      bus_rdata = 32'(en_q);
    else if (bus_addr == A_PEND_SET || bus_addr == A_PEND_CLR)
      bus_rdata = 32'(pend_q[NSRC-1:2]);
    else if (bus_addr == A_VT_BASE)
      bus_rdata = base_o;
    else begin
      for (int w = 0; w < NPW; w++) begin
        if (bus_addr == 8'(PRIO_OFF + 4 * w)) begin
          for (int l = 0; l < 4; l++) begin
            if (4 * w + l < NUM_IRQ)
              bus_rdata[8 * l + 7 -: PRIO_BITS] = prio_q[4 * w + l];
          end
        end
      end
    end
  end

  assign enable_o = {en_q, 2'b11};
  assign pend_o   = pend_q;
  assign prio_o   = prio_q;
  assign base_o   = {base_q, {VT_LSB{1'b0}}};

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC = 10,
  parameter int EW   = 3,
  parameter int IW   = 4
) (
  input  logic [NSRC-1:0]         cand,
  input  logic [NSRC-1:0][EW-1:0] eprio,
  output logic                    sel_valid,
  output logic [IW-1:0]           sel_idx,
  output logic [EW-1:0]           sel_prio
);

  // Scan from the lowest source index; only a strictly smaller value
  // replaces the holder, so ties keep the lowest exception number.
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_prio  = '1;
    for (int s = 0; s < NSRC; s++) begin
      if (cand[s] && (!sel_valid || eprio[s] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_idx   = IW'(s);
        sel_prio  = eprio[s];
      end
    end
  end

endmodule

// File: rtl/pic_active_stack.sv
module pic_active_stack #(
  parameter int NSRC   = 10,
  parameter int EW     = 3,
  parameter int IW     = 4,
  parameter int DEPTH  = 6,
  parameter int DW     = 3,
  parameter int THREAD = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IW-1:0]   push_idx,
  input  logic [EW-1:0]   push_prio,
  input  logic            pop,
  output logic [EW-1:0]   cur_prio,
  output logic [DW-1:0]   depth,
  output logic [NSRC-1:0] active
);

  logic [DEPTH-1:0][EW-1:0] prio_stk;
  logic [DEPTH-1:0][IW-1:0] idx_stk;
  logic [DW-1:0]            top;

  assign top = depth - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_stk <= '0;
      idx_stk  <= '0;
      depth    <= '0;
      active   <= '0;
    end else if (pop) begin
      if (depth != '0) begin
        active[idx_stk[top]] <= 1'b0;
        depth                <= top;
      end
    end else if (push && depth < DW'(DEPTH)) begin
      prio_stk[depth]  <= push_prio;
      idx_stk[depth]   <= push_idx;
      active[push_idx] <= 1'b1;
      depth            <= depth + 1'b1;
    end
  end

  assign cur_prio = (depth == '0) ? EW'(THREAD) : prio_stk[top];

endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_IRQ-1:0]                      irq_lvl,
  input  logic                                    nmi_lvl,
  input  logic                                    hardfault_lvl,
  input  logic                                    bus_wr,
  input  logic [7:0]                              bus_addr,
  input  logic [31:0]                             bus_wdata,
  output logic [31:0]                             bus_rdata,
  output logic                                    exc_req,
  output logic [7:0]                              exc_num,
  output logic [31:0]                             exc_vec_addr,
  input  logic                                    exc_ack,
  input  logic                                    exc_ret,
  output logic [$clog2((1<<PRIO_BITS)+3)-1:0]     cur_prio,
  output logic [31:0]                             msp_init_addr,
  output logic [31:0]                             reset_vec_addr
);

  localparam int LEVELS = 1 << PRIO_BITS;
  localparam int THREAD = LEVELS + 2;
  localparam int EW     = $clog2(LEVELS + 3);
  localparam int NSRC   = NUM_IRQ + 2;
  localparam int IW     = $clog2(NSRC);
  localparam int DEPTH  = LEVELS + 2;
  localparam int DW     = $clog2(DEPTH + 1);
  localparam int VT_LSB = $clog2((16 + NUM_IRQ) * 4);

  logic [NSRC-1:0]                   enable_vec, pend_vec, active_vec, take_oh, cand;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_vec;
  logic [NSRC-1:0][EW-1:0]           eprio;
  logic [31:0]                       base;
  logic                              sel_valid, take;
  logic [IW-1:0]                     sel_idx;
  logic [EW-1:0]                     sel_prio;
  logic [DW-1:0]                     stk_depth;

  pic_regs #(
    .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .VT_LSB(VT_LSB), .NSRC(NSRC)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_level({irq_lvl, hardfault_lvl, nmi_lvl}),
    .active(active_vec), .take_oh(take_oh),
    .enable_o(enable_vec), .pend_o(pend_vec), .prio_o(prio_vec), .base_o(base)
  );

  always_comb begin
    eprio[0] = EW'(0);
    eprio[1] = EW'(1);
    for (int k = 0; k < NUM_IRQ; k++)
      eprio[k + 2] = EW'(prio_vec[k]) + EW'(2);
  end

  assign cand = pend_vec & enable_vec;

  pic_arbiter #(.NSRC(NSRC), .EW(EW), .IW(IW)) u_arb (
    .cand(cand), .eprio(eprio),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_prio(sel_prio)
  );

  assign exc_req      = sel_valid && (sel_prio < cur_prio);
  assign exc_num      = exc_number(32'(sel_idx));
  assign exc_vec_addr = vector_addr(base, exc_num);
  assign take         = exc_req && exc_ack && !exc_ret;
  assign take_oh      = take ? (NSRC'(1) << sel_idx) : '0;

  pic_active_stack #(
    .NSRC(NSRC), .EW(EW), .IW(IW), .DEPTH(DEPTH), .DW(DW), .THREAD(THREAD)
  ) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(take), .push_idx(sel_idx), .push_prio(sel_prio), .pop(exc_ret),
    .cur_prio(cur_prio), .depth(stk_depth), .active(active_vec)
  );

  assign msp_init_addr  = vector_addr(base, 8'd0);
  assign reset_vec_addr = vector_addr(base, 8'd1);

endmodule

// File: rtl/pic_nest_chk.sv
module pic_nest_chk #(
  parameter int NSRC   = 10,
  parameter int EW     = 3,
  parameter int DW     = 3,
  parameter int THREAD = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic [7:0]      exc_num,
  input logic            exc_ret,
  input logic            take,
  input logic [NSRC-1:0] take_oh,
  input logic [NSRC-1:0] pend_vec,
  input logic [NSRC-1:0] active_vec,
  input logic [EW-1:0]   sel_prio,
  input logic [EW-1:0]   cur_prio,
  input logic [DW-1:0]   stk_depth
);

  p_req_outranks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> sel_prio < cur_prio);

  p_nest_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_prio == $past(sel_prio));

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec[0] && cur_prio != '0) |-> (exc_req && exc_num == 8'd2));

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pend_vec & $past(take_oh)) == '0);

  p_active_depth_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_vec) == 32'(stk_depth));

  p_empty_return_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && stk_depth == '0) |=> (stk_depth == '0 && cur_prio == EW'(THREAD)));

endmodule

bind pic_nest_ctrl pic_nest_chk #(
  .NSRC(NSRC), .EW(EW), .DW(DW), .THREAD(THREAD)
) u_pic_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
  .exc_ret(exc_ret), .take(take), .take_oh(take_oh), .pend_vec(pend_vec),
  .active_vec(active_vec), .sel_prio(sel_prio), .cur_prio(cur_prio),
  .stk_depth(stk_depth)
);

// File: tb/test_pic_nest_ctrl.sv
module test_pic_nest_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_lvl = '0;
  logic        nmi_lvl = 1'b0, hardfault_lvl = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        exc_req;
  logic [7:0]  exc_num;
  logic [31:0] exc_vec_addr;
  logic        exc_ack = 1'b0, exc_ret = 1'b0;
  logic [2:0]  cur_prio;
  logic [31:0] msp_init_addr, reset_vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic_nest_ctrl i_pic_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .nmi_lvl(nmi_lvl),
    .hardfault_lvl(hardfault_lvl), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exc_req(exc_req),
    .exc_num(exc_num), .exc_vec_addr(exc_vec_addr), .exc_ack(exc_ack),
    .exc_ret(exc_ret), .cur_prio(cur_prio), .msp_init_addr(msp_init_addr),
    .reset_vec_addr(reset_vec_addr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk); exc_ack = 1'b1;
    @(negedge clk); exc_ack = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); exc_ret = 1'b1;
    @(negedge clk); exc_ret = 1'b0;
  endtask

  // {enable, prio word 0x20, prio word 0x24, pending, expected exc number (0 = none)}
  localparam logic [87:0] VEC [6] = '{
    {8'hFF, 32'h00000000, 32'h00000000, 8'h01, 8'd16},
    {8'hFF, 32'h40C0C0C0, 32'hC0C0C0C0, 8'h0C, 8'd19},
    {8'hFF, 32'h80808080, 32'h80808080, 8'hA0, 8'd21},
    {8'h7F, 32'hC0C0C0C0, 32'h00C0C0C0, 8'hC0, 8'd22},
    {8'hFF, 32'hC0C07F80, 32'hC0C0C0C0, 8'h03, 8'd17},
    {8'h00, 32'h00000000, 32'h00000000, 8'hFF, 8'd0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req", 32'(exc_req), 0);
    chk("R1 prio", 32'(cur_prio), 6);
    rd(8'h00, d); chk("R1 enable", d, 0);
    rd(8'h08, d); chk("R1 pending", d, 0);
    rd(8'h10, d); chk("R1 base", d, 0);
    rd(8'h20, d); chk("R1 prio word", d, 0);
    chk("R1 msp addr", msp_init_addr, 0);
    chk("R1 reset addr", reset_vec_addr, 4);

    // R5/R9 vector table of arbitration cases
    foreach (VEC[n]) begin
      wr(8'h04, 32'hFF);
      wr(8'h0C, 32'hFF);
      wr(8'h00, 32'(VEC[n][87:80]));
      wr(8'h20, VEC[n][79:48]);
      wr(8'h24, VEC[n][47:16]);
      wr(8'h08, 32'(VEC[n][15:8]));
      if (VEC[n][7:0] == 8'd0) begin
        chk("R5 masked none", 32'(exc_req), 0);
      end else begin
        chk("R5 req", 32'(exc_req), 1);
        chk("R5 winner", 32'(exc_num), 32'(VEC[n][7:0]));
        chk("R9 vector", exc_vec_addr, 32'(VEC[n][7:0]) * 4);
      end
    end
    wr(8'h0C, 32'hFF);
    wr(8'h04, 32'hFF);

    // R2 enable set/clear
    wr(8'h00, 32'h05); rd(8'h00, d); chk("R2 set", d, 32'h05);
    wr(8'h00, 32'h02); rd(8'h04, d); chk("R2 set keep", d, 32'h07);
    wr(8'h04, 32'h01); rd(8'h00, d); chk("R2 clear", d, 32'h06);
    wr(8'h04, 32'h00); rd(8'h00, d); chk("R2 zero clear", d, 32'h06);
    wr(8'h04, 32'hFF);

    // R3 pending set/clear, disabled lines not raised
    wr(8'h08, 32'h11); rd(8'h08, d); chk("R3 set", d, 32'h11);
    wr(8'h0C, 32'h01); rd(8'h0C, d); chk("R3 clear", d, 32'h10);
    wr(8'h08, 32'h00); rd(8'h08, d); chk("R3 zero set", d, 32'h10);
    chk("R5 disabled", 32'(exc_req), 0);
    wr(8'h0C, 32'hFF);

    // R4 low priority bits dropped
    wr(8'h20, 32'hFFFFFFFF); rd(8'h20, d); chk("R4 top bits", d, 32'hC0C0C0C0);
    wr(8'h20, 32'h3F3F3F3F); rd(8'h20, d); chk("R4 low bits", d, 32'h0);
    wr(8'h24, 32'h0);

    // R6 fixed levels, R7 masking, R8 preemption
    wr(8'h00, 32'h03);
    wr(8'h08, 32'h01);
    @(negedge clk); nmi_lvl = 1'b1; hardfault_lvl = 1'b1;
    @(negedge clk);
    chk("R6 nmi wins", 32'(exc_num), 2);
    ack();
    chk("R6 nmi level", 32'(cur_prio), 0);
    chk("R7 hf masked under nmi", 32'(exc_req), 0);
    nmi_lvl = 1'b0;
    ret();
    chk("R12 restore", 32'(cur_prio), 6);
    chk("R6 hf next", 32'(exc_num), 3);
    ack();
    chk("R6 hf level", 32'(cur_prio), 1);
    chk("R7 irq under hf", 32'(exc_req), 0);
    hardfault_lvl = 1'b0;
    ret();
    chk("R5 irq0 after", 32'(exc_num), 16);
    ack();
    chk("R8 irq0 level", 32'(cur_prio), 2);
    wr(8'h08, 32'h02);
    chk("R7 equal masked", 32'(exc_req), 0);
    @(negedge clk); nmi_lvl = 1'b1;
    @(negedge clk);
    chk("R8 preempt req", 32'(exc_req), 1);
    chk("R8 preempt num", 32'(exc_num), 2);
    ack();
    nmi_lvl = 1'b0;
    chk("R8 nested level", 32'(cur_prio), 0);
    ret();
    chk("R12 pop to irq0", 32'(cur_prio), 2);
    chk("R7 still masked", 32'(exc_req), 0);
    ret();
    chk("R12 pop to thread", 32'(cur_prio), 6);
    chk("R8 irq1 raised", 32'(exc_num), 17);
    ack(); ret();

    // R11 level re-pend after return
    wr(8'h00, 32'h04);
    @(negedge clk); irq_lvl[2] = 1'b1;
    @(negedge clk);
    chk("R3 hw pend", 32'(exc_num), 18);
    ack();
    rd(8'h08, d); chk("R11 ack clears", d & 32'h04, 0);
    ret();
    chk("R11 one cycle gap", 32'(exc_req), 0);
    @(negedge clk);
    chk("R11 re-pend", 32'(exc_req), 1);
    chk("R11 re-pend num", 32'(exc_num), 18);
    irq_lvl[2] = 1'b0;
    ack(); ret();

    // R12 empty return ignored, ack with return ignored
    ret();
    chk("R12 empty return", 32'(cur_prio), 6);
    wr(8'h08, 32'h01);
    @(negedge clk); exc_ack = 1'b1; exc_ret = 1'b1;
    @(negedge clk); exc_ack = 1'b0; exc_ret = 1'b0;
    chk("R12 ack+ret prio", 32'(cur_prio), 6);
    chk("R12 ack+ret req", 32'(exc_req), 1);
    rd(8'h08, d); chk("R12 ack+ret pend", d & 32'h01, 32'h01);
    ack(); ret();

    // R13 pending-set colliding with acknowledge
    wr(8'h00, 32'h08);
    wr(8'h08, 32'h08);
    chk("R13 req", 32'(exc_num), 19);
    @(negedge clk);
    exc_ack = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h08;
    @(negedge clk);
    exc_ack = 1'b0; bus_wr = 1'b0;
    chk("R13 level", 32'(cur_prio), 2);
    rd(8'h08, d); chk("R13 pend clear", d & 32'h08, 0);
    ret();
    chk("R13 no re-raise", 32'(exc_req), 0);

    // R10 relocated base, R9 vector from it
    wr(8'h10, 32'h12345FFF);
    rd(8'h10, d); chk("R10 base", d, 32'h12345F80);
    chk("R10 msp addr", msp_init_addr, 32'h12345F80);
    chk("R10 reset addr", reset_vec_addr, 32'h12345F84);
    wr(8'h08, 32'h01);
    chk("R9 relocated vector", exc_vec_addr, 32'h12345FC0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule